// File: doc/BRIEF.md
# System Reset Request Port

This block is one byte-wide I/O register at a single fixed port address through which software asks for a system reset. The I/O decode compares each access address with the port address. Accesses to any other address do nothing to the block. The register holds one reset-type flag. Software can write it and read it back for the downstream reset logic to look at.

A write that has the trigger bit set does not change the stored flag. It produces a one-clock request pulse on `reset_req_o` in the cycle after the write. A write with the trigger bit clear keeps only the reset-type bit and drops every other bit. A read returns the stored byte one cycle later with a valid strobe. The pulse only asks for a reset. Sequencing the reset and deciding between reset flavours happen outside this block.

Top module: `sys_reset_port`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, the stored byte is 0x00, `reset_req_o` is low and `io_rvalid_o` is low.
- R2: A write to `PORT_ADDR` with data bit 2 clear stores data bit 1 as the reset-type flag. The stored byte then reads back as data AND 0x02, so every other bit reads as zero.
- R3: A write to `PORT_ADDR` with data bit 2 set drives `reset_req_o` high for exactly the one clock cycle after the write, whatever the value of data bit 1. The stored byte does not change.
- R4: `reset_req_o` is high only in the cycle after a write to `PORT_ADDR` with data bit 2 set. A write with bit 2 clear never raises it.
- R5: A read at `PORT_ADDR` raises `io_rvalid_o` for the next cycle, with `io_rdata_o` equal to the stored byte as it was before that clock edge.
- R6: Reads and writes at any address other than `PORT_ADDR` leave the stored byte unchanged, raise no reset request and keep `io_rvalid_o` low.
- R7: `io_rdata_o` is 0x00 in every cycle in which `io_rvalid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | ADDR_W (16) | I/O access address |
| io_wr_i | input | 1 | Write strobe, one cycle per access |
| io_rd_i | input | 1 | Read strobe, one cycle per access |
| io_wdata_i | input | 8 | Write data byte |
| io_rdata_o | output | 8 | Read data, valid with io_rvalid_o |
| io_rvalid_o | output | 1 | Read data valid, one cycle after a decoded read |
| reset_req_o | output | 1 | One-cycle system reset request pulse |

## Verification
The assertions check four things on every cycle. They check that each request pulse comes from a decoded trigger write one cycle earlier, and that every trigger write produces one. They check that a trigger write leaves the flag untouched and that a plain write loads exactly data bit 1. They also check that the valid strobe follows a decoded read and that read data is zero whenever the strobe is low. Only the bench's scenarios can show the full round trip from a write through a later read. That covers all 256 data values, the pulse ending after one cycle, and the mismatched addresses next to the port address, which must leave the readable value and the request output quiet.

// File: rtl/sys_rst_pkg.sv
package sys_rst_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned TRIG_BIT = 2;  // fires request, not stored
  localparam int unsigned TYPE_BIT = 1;  // only retained bit
  typedef logic [DATA_W-1:0] io_byte_t;
endpackage

// File: rtl/rst_port_decode.sv
module rst_port_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              wr_hit_o,
  output logic              rd_hit_o
);
  logic match;
  assign match    = (addr_i == PORT_ADDR);
  assign wr_hit_o = wr_i & match;
  assign rd_hit_o = rd_i & match;
endmodule

// File: rtl/rst_ctrl_store.sv
module rst_ctrl_store
  import sys_rst_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_hit_i,
  input  io_byte_t wdata_i,
  output logic     type_q_o,
  output logic     req_q_o
);
  logic trig;
  assign trig = wr_hit_i & wdata_i[TRIG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q_o <= 1'b0;
      req_q_o  <= 1'b0;
    end else begin
      req_q_o <= trig;
      if (wr_hit_i && !wdata_i[TRIG_BIT]) type_q_o <= wdata_i[TYPE_BIT];
    end
  end
endmodule

// File: rtl/rst_read_resp.sv
module rst_read_resp
  import sys_rst_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     rd_hit_i,
  input  logic     type_q_i,
  output io_byte_t rdata_o,
  output logic     rvalid_o
);
  io_byte_t byte_d;

  for (genvar i = 0; i < DATA_W; i++) begin : g_byte
    if (i == TYPE_BIT) begin : g_type
      assign byte_d[i] = type_q_i;
    end else begin : g_zero
      assign byte_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_hit_i;
      rdata_o  <= rd_hit_i ? byte_d : '0;
    end
  end
endmodule

// File: rtl/sys_reset_port.sv
module sys_reset_port
  import sys_rst_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  output logic              io_rvalid_o,
  output logic              reset_req_o
);
  logic wr_hit, rd_hit, type_q;

  rst_port_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) i_decode (
    .addr_i  (io_addr_i),
    .wr_i    (io_wr_i),
    .rd_i    (io_rd_i),
    .wr_hit_o(wr_hit),
    .rd_hit_o(rd_hit)
  );

  rst_ctrl_store i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_hit_i(wr_hit),
    .wdata_i (io_wdata_i),
    .type_q_o(type_q),
    .req_q_o (reset_req_o)
  );

  rst_read_resp i_resp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_hit_i(rd_hit),
    .type_q_i(type_q),
    .rdata_o (io_rdata_o),
    .rvalid_o(io_rvalid_o)
  );
endmodule

// File: rtl/sys_reset_port_chk.sv
module sys_reset_port_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic              io_wr_i,
  input logic              io_rd_i,
  input logic [7:0]        io_wdata_i,
  input logic [7:0]        io_rdata_o,
  input logic              io_rvalid_o,
  input logic              reset_req_o,
  input logic              type_q
);
  logic hit;
  assign hit = (io_addr_i == PORT_ADDR);

  p_req_source_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> $past(io_wr_i && hit && io_wdata_i[2]));

  p_trig_fires_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && hit && io_wdata_i[2]) |=> reset_req_o);

  p_trig_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && hit && io_wdata_i[2]) |=> $stable(type_q));

  p_store_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && hit && !io_wdata_i[2]) |=> (type_q == $past(io_wdata_i[1])));

  p_miss_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_wr_i && hit) |=> $stable(type_q));

  p_rvalid_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rvalid_o |-> $past(io_rd_i && hit));

  p_rdata_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rvalid_o |-> ((io_rdata_o & 8'hFD) == 8'h00));

  p_rdata_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rvalid_o |-> (io_rdata_o == 8'h00));
endmodule

bind sys_reset_port sys_reset_port_chk #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .io_addr_i  (io_addr_i),
  .io_wr_i    (io_wr_i),
  .io_rd_i    (io_rd_i),
  .io_wdata_i (io_wdata_i),
  .io_rdata_o (io_rdata_o),
  .io_rvalid_o(io_rvalid_o),
  .reset_req_o(reset_req_o),
  .type_q     (type_q)
);

// File: tb/test_sys_reset_port.sv
`timescale 1ns/1ps
module test_sys_reset_port;
  localparam logic [15:0] PORT = 16'h0CF9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rvalid, req;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_byte = 8'h00;
  bit done = 0;

  always #5 clk = ~clk;

  sys_reset_port #(.ADDR_W(16), .PORT_ADDR(PORT)) i_sys_reset_port (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wr_i(wr), .io_rd_i(rd),
    .io_wdata_i(wdata), .io_rdata_o(rdata), .io_rvalid_o(rvalid), .reset_req_o(req)
  );

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
    end
  endtask

  // write then observe the pulse cycle and the cycle after
  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    if (a == PORT) begin
      check(d[2] ? "R3 pulse" : "R4 no pulse", {31'd0, req}, {31'd0, d[2]});
      if (!d[2]) exp_byte = d & 8'h02;
    end else begin
      check("R6 no pulse", {31'd0, req}, 32'd0);
    end
    @(negedge clk);
    check("R3 pulse width", {31'd0, req}, 32'd0);
  endtask

  task automatic do_read(input logic [15:0] a);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    if (a == PORT) begin
      check("R5 rvalid", {31'd0, rvalid}, 32'd1);
      check("R5 rdata", {24'd0, rdata}, {24'd0, exp_byte});
    end else begin
      check("R6 rvalid", {31'd0, rvalid}, 32'd0);
      check("R7 rdata idle", {24'd0, rdata}, 32'd0);
    end
    @(negedge clk);
    check("R7 rdata after", {24'd0, rdata}, 32'd0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req", {31'd0, req}, 32'd0);
    check("R1 rvalid", {31'd0, rvalid}, 32'd0);
    do_read(PORT); // R1 stored byte zero

    // R2 R3 R4: every data value, alternating flag states
    for (int v = 0; v < 256; v++) begin
      do_write(PORT, v[7:0]);
      do_read(PORT);
    end
    // R3: trigger with bit 1 both ways from both stored states
    for (int s = 0; s < 2; s++) begin
      do_write(PORT, s[0] ? 8'h02 : 8'h00);
      do_write(PORT, 8'h04);
      do_read(PORT);
      do_write(PORT, 8'h06);
      do_read(PORT);
    end
    // R6: nearby addresses, all trying to set the flag or trigger
    do_write(PORT, 8'h00);
    for (int k = 0; k < 16; k++) begin
      logic [15:0] a;
      a = PORT ^ (16'h1 << k);
      do_write(a, 8'h02);
      do_write(a, 8'hFF);
      do_read(a);
      do_read(PORT);
    end
    // R5: read sees value before a simultaneous write
    @(negedge clk); addr = PORT; wdata = 8'h02; wr = 1'b1; rd = 1'b1;
    @(negedge clk); wr = 1'b0; rd = 1'b0;
    check("R5 pre-write value", {24'd0, rdata}, {24'd0, exp_byte});
    exp_byte = 8'h02;
    do_read(PORT);
    // R1: reset clears stored flag
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; exp_byte = 8'h00;
    check("R1 req after reset", {31'd0, req}, 32'd0);
    do_read(PORT);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule